// File: doc/BRIEF.md
# Column Command Turnaround Scheduler

This block sits in a memory controller between a queue of column commands and the column-packet pins. Each command is either a read or a write, and each moves one 16-byte data packet across a shared, bidirectional data bus. The packet occupies that bus for one slot of four clock cycles. Read data comes back a programmed read latency after the column packet. Write data is driven a shorter programmed write latency after it. The scheduler issues each command only on a column-slot boundary. It holds a command back when that command's data packet would collide with the data packet of the command before it.

A read that follows a write never waits, because the longer read latency opens the bus gap by itself. A write that follows a read is the only pairing that needs spacing on the command side. The block places the write at the first slot boundary where its data starts no earlier than the end of the read data. The block announces the first cycle of every data packet on a read-expected strobe or a write-drive strobe. The rest of the controller can launch or capture data with these strobes.

Latencies are measured from the end of the column slot to the first cycle of the data packet. A command accepted in cycle T therefore has its data strobe in cycle T + 4 + latency.

Top module: `col_turn_sched`

## Requirements
- R1: Out of reset no strobe is active and the first cycle after reset release is a slot boundary, so a read presented then is issued in that same cycle.
- R2: `cmd_ready` and `issue_stb` are high only on slot boundaries, which occur every 4 cycles counted from reset release.
- R3: A read presented right after an issued write is issued on the very next slot boundary (4 cycles later), whatever latencies are programmed.
- R4: A write that follows a read is issued at the first slot boundary at least 4 + read latency − write latency cycles after the read.
- R5: For a read issued in cycle T, `rd_data_stb` is high for exactly one cycle, in cycle T + 4 + effective read latency.
- R6: For a write issued in cycle T, `wr_data_stb` is high for exactly one cycle, in cycle T + 4 + effective write latency.
- R7: Data packets never overlap: the two strobes are never high together, and any two strobe pulses are at least 4 cycles apart.
- R8: The effective read latency is `rd_lat_cfg` clamped to the range 7 to 12 cycles.
- R9: The effective write latency is `wr_lat_cfg`, or the effective read latency minus one if `wr_lat_cfg` is not below it.
- R10: Back-to-back commands of the same type issue on consecutive slot boundaries.
- R11: Commands issue in the order presented, and `issue_is_wr` (1 = write, 0 = read) reports the type of the command accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_lat_cfg | input | 4 | Programmed read latency in cycles |
| wr_lat_cfg | input | 4 | Programmed write latency in cycles |
| cmd_valid | input | 1 | A column command is presented |
| cmd_is_wr | input | 1 | Type of the presented command: 1 write, 0 read |
| cmd_ready | output | 1 | The presented command may be issued this cycle |
| issue_stb | output | 1 | A command is issued this cycle |
| issue_is_wr | output | 1 | The issued command is a write |
| rd_data_stb | output | 1 | First cycle of an expected read data packet |
| wr_data_stb | output | 1 | First cycle of a write data packet to drive |

## Verification
Streams of a single type show that same-direction commands use every slot. Write-then-read pairs show that no stall is added where the latency difference already separates the packets. Read-then-write pairs, at a large and a small latency difference, show that the rounded-up spacing follows the difference and is not a fixed gap. Out-of-range read latencies and a write latency at or above the read latency separate the clamping from the raw settings. Pseudo-random mixes at two latency settings feed an independent overlap monitor and a timing model of each issue and data strobe.

// File: rtl/col_sched_pkg.sv
package col_sched_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } col_dir_e;

  // Read latency forced into the supported window.
  function automatic int clamp_rd(input int lat, input int lo, input int hi);
    if (lat < lo) return lo;
    if (lat > hi) return hi;
    return lat;
  endfunction

  // Write latency must stay strictly below the read latency.
  function automatic int clamp_wr(input int lat, input int rd_eff);
    if (lat >= rd_eff) return rd_eff - 1;
    return lat;
  endfunction

  // Cycles from issue to the first data cycle.
  function automatic int data_offset(input int slot, input int lat);
    return slot + lat;
  endfunction

  // Bus-busy countdown loaded in the cycle after an issue.
  function automatic int bus_hold(input int slot, input int lat);
    return 2 * slot + lat - 1;
  endfunction

endpackage

// File: rtl/col_slot_timer.sv
module col_slot_timer #(
  parameter int SLOT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_edge
);
  localparam int PH_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYC - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)                phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  assign slot_edge = (phase == '0);
endmodule

// File: rtl/col_bus_tracker.sv
module col_bus_tracker #(
  parameter int SLOT_CYC = 4,
  parameter int LAT_W    = 4,
  parameter int REM_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] cur_lat,
  input  logic             take,
  output logic             legal,
  output logic [REM_W-1:0] bus_rem
);
  import col_sched_pkg::*;

  logic [REM_W-1:0] rem_nxt;

  // Data of a command taken now starts SLOT_CYC+lat cycles ahead; it is
  // legal once that start is no earlier than the cycle the bus frees.
  assign legal = (data_offset(SLOT_CYC, int'(cur_lat)) >= int'(bus_rem));

  always_comb begin
    if (take)              rem_nxt = REM_W'(bus_hold(SLOT_CYC, int'(cur_lat)));
    else if (bus_rem != 0) rem_nxt = bus_rem - 1'b1;
    else                   rem_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rem <= '0;
    else        bus_rem <= rem_nxt;
  end
endmodule

// File: rtl/col_data_pipe.sv
module col_data_pipe #(
  parameter int SLOT_CYC = 4,
  parameter int LAT_W    = 4,
  parameter int DEPTH    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [LAT_W-1:0] lat,
  output logic             stb
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] pipe;
  logic [DEPTH-1:0] pipe_nxt;
  logic [IDX_W-1:0] idx;

  assign idx = IDX_W'(SLOT_CYC + int'(lat) - 1);

  always_comb begin
    pipe_nxt = pipe >> 1;
    if (launch) pipe_nxt = pipe_nxt | (DEPTH'(1) << idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= pipe_nxt;
  end

  assign stb = pipe[0];
endmodule

// File: rtl/col_turn_sched.sv
module col_turn_sched #(
  parameter int SLOT_CYC   = 4,
  parameter int LAT_W      = 4,
  parameter int RD_LAT_MIN = 7,
  parameter int RD_LAT_MAX = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] rd_lat_cfg,
  input  logic [LAT_W-1:0] wr_lat_cfg,
  input  logic             cmd_valid,
  input  logic             cmd_is_wr,
  output logic             cmd_ready,
  output logic             issue_stb,
  output logic             issue_is_wr,
  output logic             rd_data_stb,
  output logic             wr_data_stb
);
  import col_sched_pkg::*;

  localparam int PIPE_D  = SLOT_CYC + RD_LAT_MAX;
  localparam int REM_MAX = 2 * SLOT_CYC + RD_LAT_MAX - 1;
  localparam int REM_W   = $clog2(REM_MAX + 1);

  logic             slot_edge;
  logic             bus_legal;
  logic [REM_W-1:0] bus_rem;
  logic [LAT_W-1:0] rd_eff;
  logic [LAT_W-1:0] wr_eff;
  logic [LAT_W-1:0] cur_lat;
  logic [1:0]       data_stb;

  assign rd_eff  = LAT_W'(clamp_rd(int'(rd_lat_cfg), RD_LAT_MIN, RD_LAT_MAX));
  assign wr_eff  = LAT_W'(clamp_wr(int'(wr_lat_cfg), int'(rd_eff)));
  assign cur_lat = (col_dir_e'(cmd_is_wr) == DIR_WR) ? wr_eff : rd_eff;

  col_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_edge(slot_edge)
  );

  col_bus_tracker #(.SLOT_CYC(SLOT_CYC), .LAT_W(LAT_W), .REM_W(REM_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_lat(cur_lat),
    .take   (issue_stb),
    .legal  (bus_legal),
    .bus_rem(bus_rem)
  );

  assign cmd_ready   = slot_edge & bus_legal;
  assign issue_stb   = cmd_valid & cmd_ready;
  assign issue_is_wr = issue_stb & cmd_is_wr;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic             launch_d;
    logic [LAT_W-1:0] lat_d;
    assign launch_d = issue_stb & (cmd_is_wr == d[0]);
    assign lat_d    = d[0] ? wr_eff : rd_eff;
    col_data_pipe #(.SLOT_CYC(SLOT_CYC), .LAT_W(LAT_W), .DEPTH(PIPE_D)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .launch(launch_d),
      .lat   (lat_d),
      .stb   (data_stb[d])
    );
  end

  assign rd_data_stb = data_stb[0];
  assign wr_data_stb = data_stb[1];
endmodule

// File: rtl/col_turn_sched_chk.sv
module col_turn_sched_chk #(
  parameter int SLOT_CYC = 4,
  parameter int LAT_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_edge,
  input logic             cmd_valid,
  input logic             cmd_is_wr,
  input logic             cmd_ready,
  input logic             issue_stb,
  input logic             rd_data_stb,
  input logic             wr_data_stb,
  input logic [LAT_W-1:0] rd_eff,
  input logic [LAT_W-1:0] wr_eff
);
  logic [7:0] since_data;
  logic       seen_data;
  logic [7:0] since_issue;
  logic       seen_issue;
  logic       last_wr;
  logic       any_data;

  assign any_data = rd_data_stb | wr_data_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_data  <= '0;
      seen_data   <= 1'b0;
      since_issue <= '0;
      seen_issue  <= 1'b0;
      last_wr     <= 1'b0;
    end else begin
      if (any_data) begin
        since_data <= 8'd1;
        seen_data  <= 1'b1;
      end else if (since_data != 8'hFF) begin
        since_data <= since_data + 8'd1;
      end
      if (issue_stb) begin
        since_issue <= 8'd1;
        seen_issue  <= 1'b1;
        last_wr     <= cmd_is_wr;
      end else if (since_issue != 8'hFF) begin
        since_issue <= since_issue + 8'd1;
      end
    end
  end

  AST_READY_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> slot_edge); // R2

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data_stb && wr_data_stb)); // R7

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (any_data && seen_data) |-> (int'(since_data) >= SLOT_CYC)); // R7

  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && cmd_valid && !cmd_is_wr && seen_issue && last_wr &&
     int'(since_issue) == SLOT_CYC) |-> cmd_ready); // R3

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_stb && cmd_is_wr && seen_issue && !last_wr) |->
    (int'(since_issue) >= SLOT_CYC + int'(rd_eff) - int'(wr_eff))); // R4
endmodule

bind col_turn_sched col_turn_sched_chk #(.SLOT_CYC(SLOT_CYC), .LAT_W(LAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_edge  (slot_edge),
  .cmd_valid  (cmd_valid),
  .cmd_is_wr  (cmd_is_wr),
  .cmd_ready  (cmd_ready),
  .issue_stb  (issue_stb),
  .rd_data_stb(rd_data_stb),
  .wr_data_stb(wr_data_stb),
  .rd_eff     (rd_eff),
  .wr_eff     (wr_eff)
);

// File: tb/col_turn_sched_bench.sv
`timescale 1ns/1ps
module col_turn_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rd_lat_cfg = 4'd7;
  logic [3:0] wr_lat_cfg = 4'd3;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_wr = 1'b0;
  logic       cmd_ready, issue_stb, issue_is_wr, rd_data_stb, wr_data_stb;

  int errors = 0;
  int checks = 0;
  int bcyc = 0;
  int last_ds = -100;
  int n_got = 0;
  int got_ds[64];
  bit got_dw[64];
  int got_issue[64];
  int exp_issue[64];
  int exp_ds[64];
  bit seq_wr[64];
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  col_turn_sched u_col_turn_sched (
    .clk(clk), .rst_n(rst_n), .rd_lat_cfg(rd_lat_cfg), .wr_lat_cfg(wr_lat_cfg),
    .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr), .cmd_ready(cmd_ready),
    .issue_stb(issue_stb), .issue_is_wr(issue_is_wr),
    .rd_data_stb(rd_data_stb), .wr_data_stb(wr_data_stb)
  );

  always @(posedge clk) begin
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Data strobe monitor; strobes are registered so they are stable here.
  always @(negedge clk) begin
    if (rst_n && (rd_data_stb || wr_data_stb)) begin
      chk(!(rd_data_stb && wr_data_stb), "R7 both strobes", 1, 0);
      chk((bcyc - last_ds) >= 4, "R7 packet spacing", bcyc - last_ds, 4);
      last_ds = bcyc;
      if (n_got < 64) begin
        got_ds[n_got] = bcyc;
        got_dw[n_got] = wr_data_stb;
      end
      n_got++;
    end
  end

  function automatic int ceil4(input int x);
    return ((x + 3) / 4) * 4;
  endfunction

  // Caller is positioned at a negedge.
  task automatic run_seq(input int n, input int rdl, input int wrl, input int idle,
                         input string tag);
    int er, ew, first_b, cand, lat;
    rd_lat_cfg = 4'(rdl);
    wr_lat_cfg = 4'(wrl);
    repeat (idle) @(negedge clk);
    n_got = 0;
    er = (rdl < 7) ? 7 : ((rdl > 12) ? 12 : rdl);
    ew = (wrl >= er) ? er - 1 : wrl;
    first_b = bcyc;
    for (int k = 0; k < n; k++) begin
      cmd_valid = 1'b1;
      cmd_is_wr = seq_wr[k];
      #1;
      while (!cmd_ready) begin
        @(negedge clk);
        #1;
      end
      got_issue[k] = bcyc;
      chk(issue_stb == 1'b1, "R11 issue strobe", int'(issue_stb), 1);
      chk(issue_is_wr == seq_wr[k], "R11 issue type", int'(issue_is_wr), int'(seq_wr[k]));
      chk((bcyc % 4) == 0, "R2 slot boundary", bcyc % 4, 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    repeat (40) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      lat = seq_wr[k] ? ew : er;
      cand = (k == 0) ? first_b : ((exp_issue[k-1] + 1 > exp_ds[k-1] - lat) ?
                                    exp_issue[k-1] + 1 : exp_ds[k-1] - lat);
      exp_issue[k] = ceil4(cand);
      exp_ds[k] = exp_issue[k] + 4 + lat;
      chk(got_issue[k] == exp_issue[k], tag, got_issue[k], exp_issue[k]);
      if (k < n_got) begin
        chk(got_ds[k] == exp_ds[k], seq_wr[k] ? "R6 write data cycle" : "R5 read data cycle",
            got_ds[k], exp_ds[k]);
        chk(got_dw[k] == seq_wr[k], "R11 data order", int'(got_dw[k]), int'(seq_wr[k]));
      end
    end
    chk(n_got == n, "R5 R6 strobe count", n_got, n);
  endtask

  task automatic t_reset;
    rd_lat_cfg = 4'd7;
    wr_lat_cfg = 4'd3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk(rd_data_stb == 1'b0 && wr_data_stb == 1'b0, "R1 strobes after reset",
        int'(rd_data_stb) + int'(wr_data_stb), 0);
    chk(issue_stb == 1'b0, "R1 no issue while idle", int'(issue_stb), 0);
    seq_wr[0] = 1'b0;
    run_seq(1, 7, 3, 0, "R1 first slot issue");
  endtask

  task automatic t_same_type;
    for (int k = 0; k < 4; k++) seq_wr[k] = 1'b0;
    for (int k = 4; k < 8; k++) seq_wr[k] = 1'b1;
    run_seq(8, 7, 3, 10, "R10 same type stream");
  endtask

  task automatic t_wr_then_rd;
    seq_wr[0] = 1'b1; seq_wr[1] = 1'b0; seq_wr[2] = 1'b1; seq_wr[3] = 1'b0;
    run_seq(4, 8, 5, 10, "R3 read after write");
  endtask

  task automatic t_rd_then_wr;
    seq_wr[0] = 1'b0; seq_wr[1] = 1'b1;
    run_seq(2, 12, 2, 10, "R4 write after read wide");
    chk(got_issue[1] - got_issue[0] == 16, "R4 spacing wide", got_issue[1] - got_issue[0], 16);
    run_seq(2, 9, 7, 10, "R4 write after read narrow");
    chk(got_issue[1] - got_issue[0] == 8, "R4 spacing narrow", got_issue[1] - got_issue[0], 8);
  endtask

  task automatic t_clamp;
    seq_wr[0] = 1'b0; seq_wr[1] = 1'b0;
    run_seq(2, 2, 1, 10, "R8 low clamp issue");
    chk(got_ds[0] - got_issue[0] == 11, "R8 low clamp latency", got_ds[0] - got_issue[0], 11);
    seq_wr[0] = 1'b0; seq_wr[1] = 1'b1;
    run_seq(2, 15, 3, 10, "R8 high clamp issue");
    chk(got_ds[0] - got_issue[0] == 16, "R8 high clamp latency", got_ds[0] - got_issue[0], 16);
    seq_wr[0] = 1'b1; seq_wr[1] = 1'b0; seq_wr[2] = 1'b1;
    run_seq(3, 8, 11, 10, "R9 write clamp issue");
    chk(got_ds[0] - got_issue[0] == 11, "R9 write clamp latency", got_ds[0] - got_issue[0], 11);
  endtask

  task automatic t_random(input int rdl, input int wrl);
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      seq_wr[k] = lfsr[0];
    end
    run_seq(24, rdl, wrl, 10, "R7 random mix issue");
  endtask

  initial begin
    t_reset();
    t_same_type();
    t_wr_then_rd();
    t_rd_then_wr();
    t_clamp();
    t_random(10, 4);
    t_random(7, 6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", bcyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule